// File: doc/BRIEF.md
# Four-Channel MDIO Management Slave

This block is the management-port slave of a four-channel transceiver. A station manager drives a slow management clock and a shared bidirectional data line. The block oversamples both with the system clock and takes each data bit on the rising edge of the management clock. It decodes standard two-wire management frames and answers for four channels, each at its own PHY address. The upper three address bits come from strap inputs, and the lower two bits are the channel number, fixed in the block.

Each channel has eight 16-bit registers. These are a control word, a set of latched change flags that clear when read, the live status, an interrupt mask, a fixed identifier, two scratch words and a mode word. The mode word holds the enable for burst access. When burst access is enabled, register address 31 carries all eight registers of the channel in one frame, in ascending order. Software can watch status by polling, or it can use the interrupt output, which is high while any unmasked change flag is set on any channel.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: Synchronous reset returns the frame decoder to preamble hunt, releases the data line (`mdio_oe`=0), drops `irq`, and restores the register defaults: control 0x1140, mask 0, scratch 0, mode 0. This holds even when reset arrives in the middle of a frame.
- R2: A frame is acted on only when its PHY address equals {strap_addr, channel}, where channel 0..3 is the low two bits. For any other address the block never drives the line and writes nothing.
- R3: A frame is recognised only after at least 32 consecutive ones followed by the start pattern 0,1. With 31 ones the frame is ignored.
- R4: The opcode is 10 for read and 01 for write. The opcodes 00 and 11 abort the frame without any register change, and the block goes back to preamble hunt.
- R5: On a matching read, the line is released during the first turnaround bit and driven 0 during the second. The 16 data bits then follow MSB first, each updated after a rising MDC edge. The line is released after the last data bit.
- R6: Register map, by address: 0 control (all bits writable), 1 change flags (read-only), 2 live status (read-only), 3 interrupt mask (writable, 1 = enabled), 4 identifier 0x7A00 | channel (read-only), 5 and 6 scratch (writable), 7 mode (bit 0 burst enable is writable, bits 15:1 read 0). Writes leave read-only bits unchanged. Addresses 8 to 31 read 0 and ignore writes.
- R7: With mode bit 0 set, a read of address 31 returns registers 0 to 7 of that channel in ascending order, 128 bits back to back.
- R8: With mode bit 0 clear, address 31 is an ordinary single register. It reads as 16 zero bits, and a 16-bit write to it has no effect.
- R9: With mode bit 0 set, a write to address 31 takes 128 bits and updates the writable bits of registers 0 to 7 in order.
- R10: If MDC stops for more than 64 system clocks in the middle of a frame, the frame is abandoned and the block returns to preamble hunt. Registers completed before the stop keep their new values, and a partially received register is not changed.
- R11: A change-flag bit is set when the matching live status bit changes, and it stays set. Reading register 1, alone or in a burst, returns the flags and clears them.
- R12: `irq` is high while any channel has a change flag set whose mask bit is 1. It goes low once those flags have been read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the management pins |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Value seen on the shared data line |
| strap_addr | input | 3 | Upper three PHY address bits from strap pins |
| status_in | input | 64 | Live status, 16 bits per channel, channel 0 in the low bits |
| mdio_o | output | 1 | Data the slave drives on the line |
| mdio_oe | output | 1 | Enable for the line driver, active high |
| irq | output | 1 | Interrupt, active high |

## Verification
The hardest case to reach from the ports is a burst write that breaks off partway through a register. To set it up, the bench enables burst mode through a single write, then clocks in three full words and half of a fourth, and then holds MDC still past the quiet limit. A following single read of both the completed register and the partial one shows whether the timeout reset the decoder and discarded only the unfinished word. The interrupt path needs a similar setup: a mask bit is written first, then status lines are toggled both outside and inside the mask. Only the second toggle may raise `irq`, and the flag read must lower it.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int DW   = 16;             // data bits per register
  localparam int NREG = 8;              // registers per channel
  localparam int RAW  = 5;              // register address field width
  localparam int PAW  = 5;              // PHY address field width
  localparam int WB   = $clog2(DW);     // bit index inside a word
  localparam int IB   = $clog2(NREG);   // register index inside a burst
  localparam int BW   = WB + IB;        // burst bit counter width

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [RAW-1:0] BURST_ADDR = '1;

  localparam logic [IB-1:0] RI_CTRL = 3'd0;
  localparam logic [IB-1:0] RI_FLAG = 3'd1;
  localparam logic [IB-1:0] RI_LIVE = 3'd2;
  localparam logic [IB-1:0] RI_MASK = 3'd3;
  localparam logic [IB-1:0] RI_ID   = 3'd4;
  localparam logic [IB-1:0] RI_SCR0 = 3'd5;
  localparam logic [IB-1:0] RI_SCR1 = 3'd6;
  localparam logic [IB-1:0] RI_MODE = 3'd7;

  typedef enum logic [2:0] {
    S_PRE, S_ST, S_OP, S_PHY, S_REG, S_TA, S_DAT
  } frm_state_t;

  // bits a management write may change
  function automatic logic [DW-1:0] wr_mask(input logic [IB-1:0] idx);
    case (idx)
      RI_CTRL, RI_MASK, RI_SCR0, RI_SCR1: wr_mask = '1;
      RI_MODE: wr_mask = DW'(1);
      default: wr_mask = '0;
    endcase
  endfunction

endpackage

// File: rtl/mdio_pin_sync.sv
module mdio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdio_bit
);
  logic [STAGES-1:0] mdc_sh;
  logic [STAGES-1:0] dat_sh;
  logic              mdc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_sh <= '0;
      dat_sh <= '1;
      mdc_d  <= 1'b0;
    end else begin
      mdc_sh <= {mdc_sh[STAGES-2:0], mdc};
      dat_sh <= {dat_sh[STAGES-2:0], mdio_i};
      mdc_d  <= mdc_sh[STAGES-1];
    end
  end

  assign mdc_rise = mdc_sh[STAGES-1] & ~mdc_d;
  assign mdio_bit = dat_sh[STAGES-1];

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_mgmt_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int PRE_LEN = 32,
  parameter int IDLE_TO = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mdc_rise,
  input  logic            mdio_bit,
  input  logic [2:0]      strap_addr,
  input  logic [NCH-1:0]  burst_en,
  input  logic [DW-1:0]   rd_data,
  output logic            mdio_o,
  output logic            mdio_oe,
  output logic [1:0]      chan,
  output logic            rd_en,
  output logic [RAW-1:0]  rd_addr,
  output logic            wr_en,
  output logic [RAW-1:0]  wr_addr,
  output logic [DW-1:0]   wr_data
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int ITW = $clog2(IDLE_TO + 1);

  frm_state_t       state;
  logic [PCW-1:0]   pre_cnt;
  logic [2:0]       cnt;
  logic [3:0]       sh;
  logic             is_rd, hit, burst;
  logic [PAW-1:0]   phy_q;
  logic [RAW-1:0]   reg_q;
  logic [BW-1:0]    bc;
  logic [DW-1:0]    dsh;
  logic [ITW-1:0]   idle;

  logic [1:0]       opc;
  logic [4:0]       field;
  logic             hit_c, brst_c, timeout, word_end;
  logic [BW-1:0]    last;
  logic [IB-1:0]    rd_idx;

  assign opc      = {sh[0], mdio_bit};
  assign field    = {sh, mdio_bit};
  assign hit_c    = (phy_q[4:2] == strap_addr) && (int'(phy_q[1:0]) < NCH);
  assign brst_c   = (field == BURST_ADDR) && burst_en[phy_q[1:0]];
  assign timeout  = !mdc_rise && (state != S_PRE) && (idle == ITW'(IDLE_TO - 1));
  assign last     = burst ? BW'(NREG*DW - 1) : BW'(DW - 1);
  assign word_end = (bc[WB-1:0] == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_PRE; pre_cnt <= '0; cnt <= '0; sh <= '0;
      is_rd <= 1'b0; hit <= 1'b0; burst <= 1'b0;
      phy_q <= '0; reg_q <= '0; bc <= '0; dsh <= '0;
      mdio_oe <= 1'b0; mdio_o <= 1'b0; idle <= '0;
    end else begin
      idle <= (mdc_rise || state == S_PRE || timeout) ? '0 : idle + 1'b1;
      if (timeout) begin
        state   <= S_PRE;
        pre_cnt <= '0;
        mdio_oe <= 1'b0;
      end else if (mdc_rise) begin
        case (state)
          S_PRE: begin
            if (mdio_bit) begin
              if (pre_cnt != PCW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
            end else if (pre_cnt == PCW'(PRE_LEN)) begin
              state <= S_ST;
            end else begin
              pre_cnt <= '0;
            end
          end
          S_ST: begin
            pre_cnt <= '0;
            cnt     <= '0;
            state   <= mdio_bit ? S_OP : S_PRE;
          end
          S_OP: begin
            sh <= {sh[2:0], mdio_bit};
            if (cnt == 3'd0) cnt <= 3'd1;
            else begin
              cnt <= '0;
              if (opc == OP_RD || opc == OP_WR) begin
                is_rd <= (opc == OP_RD);
                state <= S_PHY;
              end else begin
                state <= S_PRE;
              end
            end
          end
          S_PHY: begin
            sh <= {sh[2:0], mdio_bit};
            if (cnt == 3'd4) begin
              phy_q <= field;
              cnt   <= '0;
              state <= S_REG;
            end else cnt <= cnt + 1'b1;
          end
          S_REG: begin
            sh <= {sh[2:0], mdio_bit};
            if (cnt == 3'd4) begin
              reg_q   <= field;
              hit     <= hit_c;
              burst   <= brst_c;
              cnt     <= '0;
              mdio_oe <= 1'b0;
              state   <= S_TA;
            end else cnt <= cnt + 1'b1;
          end
          S_TA: begin
            if (cnt == 3'd0) begin
              cnt <= 3'd1;
              if (is_rd && hit) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              cnt   <= '0;
              bc    <= '0;
              state <= S_DAT;
              if (is_rd && hit) begin
                mdio_o <= rd_data[DW-1];
                dsh    <= {rd_data[DW-2:0], 1'b0};
              end
            end
          end
          S_DAT: begin
            if (is_rd) begin
              if (bc == last) begin
                mdio_oe <= 1'b0;
                state   <= S_PRE;
              end else begin
                bc <= bc + 1'b1;
                if (word_end) begin
                  mdio_o <= rd_data[DW-1];
                  dsh    <= {rd_data[DW-2:0], 1'b0};
                end else begin
                  mdio_o <= dsh[DW-1];
                  dsh    <= {dsh[DW-2:0], 1'b0};
                end
              end
            end else begin
              dsh <= {dsh[DW-2:0], mdio_bit};
              if (bc == last) state <= S_PRE;
              else bc <= bc + 1'b1;
            end
          end
          default: state <= S_PRE;
        endcase
      end
    end
  end

  assign rd_idx  = (state == S_DAT) ? bc[BW-1:WB] + 1'b1 : '0;
  assign chan    = phy_q[1:0];
  assign rd_en   = mdc_rise && is_rd && hit &&
                   ((state == S_TA && cnt != 3'd0) ||
                    (state == S_DAT && bc != last && word_end));
  assign rd_addr = burst ? RAW'(rd_idx) : reg_q;
  assign wr_en   = mdc_rise && (state == S_DAT) && !is_rd && hit && word_end;
  assign wr_addr = burst ? RAW'(bc[BW-1:WB]) : reg_q;
  assign wr_data = {dsh[DW-2:0], mdio_bit};

  // R2: the line is only ever driven for a matching read
  a_r2_drive_needs_match: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> (hit && is_rd));

  // R3: start is only taken after a full preamble
  a_r3_full_preamble: assert property (@(posedge clk) disable iff (rst)
    (state == S_ST && $past(state) == S_PRE) |-> $past(pre_cnt) == PCW'(PRE_LEN));

  // R4: an illegal opcode returns to preamble hunt
  a_r4_bad_op_abort: assert property (@(posedge clk) disable iff (rst)
    (mdc_rise && state == S_OP && cnt == 3'd1 && opc != OP_RD && opc != OP_WR)
    |=> state == S_PRE);

  // R5: first turnaround bit never sees the slave driving
  a_r5_ta_released: assert property (@(posedge clk) disable iff (rst)
    (state == S_TA && cnt == 3'd0) |-> !mdio_oe);

  // R10: the quiet counter never passes its limit
  a_r10_quiet_bound: assert property (@(posedge clk) disable iff (rst)
    idle < ITW'(IDLE_TO));

endmodule

// File: rtl/mdio_chan_regs.sv
module mdio_chan_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int          CH       = 0,
  parameter logic [15:0] CTRL_DEF = 16'h1140,
  parameter logic [15:0] ID_BASE  = 16'h7A00
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  status,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [RAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           irq_src,
  output logic           burst_en
);
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] flags, prev;
  logic [DW-1:0] chg, m;
  logic [IB-1:0] widx, ridx;
  logic          wr_ok, clr;

  assign widx  = wr_addr[IB-1:0];
  assign ridx  = rd_addr[IB-1:0];
  assign wr_ok = wr_en && (wr_addr[RAW-1:IB] == '0);
  assign m     = wr_mask(widx);
  assign chg   = status ^ prev;
  assign clr   = rd_en && (rd_addr == RAW'(RI_FLAG));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++)
        rf[i] <= (IB'(i) == RI_CTRL) ? CTRL_DEF : '0;
    end else if (wr_ok) begin
      rf[widx] <= (rf[widx] & ~m) | (wr_data & m);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      flags <= '0;
    end else begin
      prev  <= status;
      flags <= (clr ? '0 : flags) | chg;
    end
  end

  always_comb begin
    if (rd_addr[RAW-1:IB] != '0) rd_data = '0;
    else begin
      case (ridx)
        RI_FLAG: rd_data = flags;
        RI_LIVE: rd_data = status;
        RI_ID:   rd_data = ID_BASE | DW'(CH);
        default: rd_data = rf[ridx];
      endcase
    end
  end

  assign irq_src  = |(flags & rf[RI_MASK]);
  assign burst_en = rf[RI_MODE][0];

  // R11: after a clearing read only fresh changes remain flagged
  a_r11_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> ((flags & ~$past(chg)) == '0));

  // R6: a write to the identifier slot never alters the stored word
  a_r6_ro_untouched: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && widx == RI_ID) |=> $stable(rf[RI_ID]));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int          NCH         = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int          PRE_LEN     = 32,
  parameter int          IDLE_TO     = 64,
  parameter logic [15:0] CTRL_DEF    = 16'h1140,
  parameter logic [15:0] ID_BASE     = 16'h7A00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc,
  input  logic              mdio_i,
  input  logic [2:0]        strap_addr,
  input  logic [NCH*DW-1:0] status_in,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              irq
);
  logic           mdc_rise, mdio_bit;
  logic [1:0]     chan;
  logic           rd_en, wr_en;
  logic [RAW-1:0] rd_addr, wr_addr;
  logic [DW-1:0]  wr_data, rd_data;
  logic [NCH-1:0] burst_en, irq_vec;
  logic [DW-1:0]  rd_vec [NCH];

  mdio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i),
    .mdc_rise(mdc_rise), .mdio_bit(mdio_bit)
  );

  mdio_frame #(.NCH(NCH), .PRE_LEN(PRE_LEN), .IDLE_TO(IDLE_TO)) u_frame (
    .clk(clk), .rst(rst), .mdc_rise(mdc_rise), .mdio_bit(mdio_bit),
    .strap_addr(strap_addr), .burst_en(burst_en), .rd_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .chan(chan),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = (int'(chan) == g);
    mdio_chan_regs #(.CH(g), .CTRL_DEF(CTRL_DEF), .ID_BASE(ID_BASE)) u_regs (
      .clk(clk), .rst(rst),
      .status(status_in[g*DW +: DW]),
      .wr_en(wr_en && sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en && sel), .rd_addr(rd_addr),
      .rd_data(rd_vec[g]), .irq_src(irq_vec[g]), .burst_en(burst_en[g])
    );
  end

  assign rd_data = rd_vec[chan];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |irq_vec;
  end

  // R12: interrupt only follows an unmasked flag of some channel
  a_r12_irq_has_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|irq_vec));

  // R1: nothing is driven in the cycle after reset is released
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!mdio_oe && !irq));

endmodule

// File: tb/mdio_mgmt_slave_tb.sv
`timescale 1ns/100ps
module mdio_mgmt_slave_tb;
  localparam int NCH = 4;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic mdc = 1'b0;
  logic mst_en = 1'b0, mst_bit = 1'b1;
  logic [NCH*16-1:0] status_in = '0;
  logic mdio_o, mdio_oe, irq;
  logic line_now, mdio_in;

  assign line_now = mdio_oe ? mdio_o : 1'b1;
  assign mdio_in  = mst_en ? mst_bit : line_now;

  mdio_mgmt_slave u_dut (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_in),
    .strap_addr(STRAP), .status_in(status_in),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq(irq)
  );

  int n_vec = 0, n_err = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        cap_en = 1'b0;
  logic        oe_seen = 1'b0, oe_pre = 1'b0, o_pre = 1'b0;
  logic [15:0] wbuf [8];
  bit          done = 1'b0;

  function automatic logic [4:0] pa(input int ch);
    return {STRAP, 2'(ch)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic bit_cycle(input logic b);
    mst_bit = b;
    repeat (4) begin @(negedge clk); oe_seen |= mdio_oe; end
    oe_pre = mdio_oe;
    o_pre  = mdio_o;
    mdc = 1'b1;
    repeat (4) begin @(negedge clk); oe_seen |= mdio_oe; end
    mdc = 1'b0;
  endtask

  task automatic send_hdr(input int npre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    mst_en = 1'b1;
    repeat (npre) bit_cycle(1'b1);
    bit_cycle(1'b0); bit_cycle(1'b1);
    for (int i = 1; i >= 0; i--) bit_cycle(op[i]);
    for (int i = 4; i >= 0; i--) bit_cycle(phy[i]);
    for (int i = 4; i >= 0; i--) bit_cycle(ra[i]);
  endtask

  task automatic wr_frame(input int npre, input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] ra, input int nbits);
    send_hdr(npre, op, phy, ra);
    bit_cycle(1'b1); bit_cycle(1'b0);
    for (int i = 0; i < nbits; i++) bit_cycle(wbuf[i/16][15 - (i % 16)]);
    mst_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_frame(input logic [4:0] phy, input logic [4:0] ra, input int nwords, input bit hit);
    oe_seen = 1'b0;
    send_hdr(32, 2'b10, phy, ra);
    mst_en = 1'b0;
    bit_cycle(1'b1);
    if (hit) chk(oe_pre == 1'b0, "R5 ta1 released", 16'(oe_pre), 16'h0);
    bit_cycle(1'b1);
    if (hit) chk(oe_pre == 1'b1 && o_pre == 1'b0, "R5 ta2 zero", {oe_pre, o_pre}, 16'h2);
    cap_en = hit;
    repeat (16*nwords) bit_cycle(1'b1);
    cap_en = 1'b0;
    repeat (4) @(negedge clk);
    if (hit) chk(mdio_oe == 1'b0, "R5 released after data", 16'(mdio_oe), 16'h0);
    else     chk(oe_seen == 1'b0, "R2 no drive on mismatch", 16'(oe_seen), 16'h0);
  endtask

  // monitor: collects driven words and pops the scoreboard
  initial begin
    int nb = 0;
    logic [15:0] w = '0;
    forever begin
      @(posedge mdc);
      if (cap_en) begin
        w = {w[14:0], line_now};
        nb++;
        if (nb == 16) begin
          nb = 0;
          if (exp_q.size() == 0) chk(1'b0, "unexpected word", w, 16'hxxxx);
          else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(w === e, t, w, e);
          end
        end
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mdio_oe == 1'b0, "R1 oe after reset", 16'(mdio_oe), 16'h0);
    chk(irq == 1'b0, "R1 irq after reset", 16'(irq), 16'h0);
    push(16'h1140, "R1 ctrl default"); rd_frame(pa(0), 5'd0, 1, 1);
    push(16'h7A02, "R6 id ch2");       rd_frame(pa(2), 5'd4, 1, 1);
    push(16'h0000, "R1 mode default"); rd_frame(pa(1), 5'd7, 1, 1);

    // R6 writable and read-only bits
    wbuf[0] = 16'hBEEF; wr_frame(32, 2'b01, pa(1), 5'd0, 16);
    push(16'hBEEF, "R6 ctrl write");   rd_frame(pa(1), 5'd0, 1, 1);
    wbuf[0] = 16'h1234; wr_frame(32, 2'b01, pa(1), 5'd4, 16);
    push(16'h7A01, "R6 id read-only"); rd_frame(pa(1), 5'd4, 1, 1);
    wbuf[0] = 16'hFFFF; wr_frame(32, 2'b01, pa(1), 5'd7, 16);
    push(16'h0001, "R6 mode bit0 only"); rd_frame(pa(1), 5'd7, 1, 1);

    // R2 mismatched strap bits
    rd_frame({3'b100, 2'd1}, 5'd0, 1, 0);
    wbuf[0] = 16'h5555; wr_frame(32, 2'b01, {3'b100, 2'd1}, 5'd5, 16);
    push(16'h0000, "R2 mismatch write ignored"); rd_frame(pa(1), 5'd5, 1, 1);

    // R3 preamble length
    wbuf[0] = 16'hAAAA; wr_frame(31, 2'b01, pa(0), 5'd5, 16);
    push(16'h0000, "R3 short preamble ignored"); rd_frame(pa(0), 5'd5, 1, 1);
    wr_frame(32, 2'b01, pa(0), 5'd5, 16);
    push(16'hAAAA, "R3 full preamble accepted"); rd_frame(pa(0), 5'd5, 1, 1);

    // R4 illegal opcodes
    wbuf[0] = 16'h1111; wr_frame(32, 2'b11, pa(0), 5'd5, 16);
    push(16'hAAAA, "R4 opcode 11 aborted"); rd_frame(pa(0), 5'd5, 1, 1);
    wr_frame(32, 2'b00, pa(0), 5'd5, 16);
    push(16'hAAAA, "R4 opcode 00 aborted"); rd_frame(pa(0), 5'd5, 1, 1);

    // R8 address 31 without burst enable
    push(16'h0000, "R8 single read of 31"); rd_frame(pa(2), 5'd31, 1, 1);
    wbuf[0] = 16'hFFFF; wr_frame(32, 2'b01, pa(2), 5'd31, 16);
    push(16'h0000, "R8 write to 31 no effect"); rd_frame(pa(2), 5'd7, 1, 1);

    // R7 burst read, ch1 has burst enabled
    push(16'hBEEF, "R7 burst r0"); push(16'h0000, "R7 burst r1");
    push(16'h0000, "R7 burst r2"); push(16'h0000, "R7 burst r3");
    push(16'h7A01, "R7 burst r4"); push(16'h0000, "R7 burst r5");
    push(16'h0000, "R7 burst r6"); push(16'h0001, "R7 burst r7");
    rd_frame(pa(1), 5'd31, 8, 1);

    // R9 burst write
    wbuf[0] = 16'h0101; wbuf[1] = 16'hFFFF; wbuf[2] = 16'hFFFF; wbuf[3] = 16'h00F0;
    wbuf[4] = 16'hFFFF; wbuf[5] = 16'h5A5A; wbuf[6] = 16'hA5A5; wbuf[7] = 16'h0001;
    wr_frame(32, 2'b01, pa(1), 5'd31, 128);
    push(16'h0101, "R9 burst w0"); push(16'h0000, "R9 burst w1 ro");
    push(16'h0000, "R9 burst w2 ro"); push(16'h00F0, "R9 burst w3");
    push(16'h7A01, "R9 burst w4 ro"); push(16'h5A5A, "R9 burst w5");
    push(16'hA5A5, "R9 burst w6"); push(16'h0001, "R9 burst w7");
    rd_frame(pa(1), 5'd31, 8, 1);

    // R10 burst write that stops inside register 3
    wbuf[0] = 16'h1111; wbuf[1] = 16'h2222; wbuf[2] = 16'h2222; wbuf[3] = 16'h3333;
    wr_frame(32, 2'b01, pa(1), 5'd31, 56);
    repeat (100) @(negedge clk);
    push(16'h1111, "R10 completed word kept"); rd_frame(pa(1), 5'd0, 1, 1);
    push(16'h00F0, "R10 partial word dropped"); rd_frame(pa(1), 5'd3, 1, 1);

    // R11 / R12 latched flags and interrupt
    wbuf[0] = 16'h0004; wr_frame(32, 2'b01, pa(3), 5'd3, 16);
    status_in[3*16 +: 16] = 16'h0003;
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R12 masked change no irq", 16'(irq), 16'h0);
    status_in[3*16 +: 16] = 16'h0007;
    repeat (10) @(negedge clk);
    chk(irq == 1'b1, "R12 unmasked change irq", 16'(irq), 16'h1);
    push(16'h0007, "R11 flags latched"); rd_frame(pa(3), 5'd1, 1, 1);
    chk(irq == 1'b0, "R12 irq low after read", 16'(irq), 16'h0);
    push(16'h0000, "R11 flags cleared"); rd_frame(pa(3), 5'd1, 1, 1);
    push(16'h0007, "R11 live status");   rd_frame(pa(3), 5'd2, 1, 1);

    // R1 reset in the middle of a write frame
    status_in[3*16 +: 16] = 16'h0003;
    repeat (10) @(negedge clk);
    chk(irq == 1'b1, "R12 irq before reset", 16'(irq), 16'h1);
    send_hdr(32, 2'b01, pa(1), 5'd0);
    bit_cycle(1'b1); bit_cycle(1'b0);
    repeat (5) bit_cycle(1'b0);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq == 1'b0, "R1 irq in reset", 16'(irq), 16'h0);
    chk(mdio_oe == 1'b0, "R1 oe in reset", 16'(mdio_oe), 16'h0);
    rst = 1'b0;
    mst_en = 1'b0;
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R1 mask cleared by reset", 16'(irq), 16'h0);
    push(16'h1140, "R1 ctrl restored"); rd_frame(pa(1), 5'd0, 1, 1);
    push(16'h0000, "R1 mode restored"); rd_frame(pa(1), 5'd7, 1, 1);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7 scoreboard drained", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    finish_run();
  end

endmodule